// File: doc/BRIEF.md
# Voice-Activated Wake-Up Supervisor

This always-on controller sits between a voice activity detector and a speech recognizer whose power can be switched off. The detector delivers one speech/non-speech verdict per audio frame. When a frame is marked as speech, the supervisor switches on the recognizer's power gate and waits for the supply to settle. Only then does it release the recognizer's reset. It holds the domain on until a programmable number of consecutive non-speech frames has gone by. It then removes power and puts the domain back into reset. A speech frame that arrives during that hangover interval cancels the countdown.

Audio samples keep arriving whatever the power state. The supervisor writes every sample into a 1024-entry circular store. At wake-up it places the read position a programmable pre-roll distance behind the newest sample, so the recognizer can fetch the onset of speech that triggered the wake-up. The recognizer pulls samples one at a time with a read request. Each request is answered one cycle later, either with data or with an underflow pulse. If the recognizer falls more than a full store behind, the oldest unread sample is dropped and a sticky overflow flag is raised.

Top module: `wake_supervisor`

## Requirements
- R1: After reset the power enable, the downstream reset release (`dom_rst_n`), `rd_valid`, `rd_underflow` and `overflow` are all low.
- R2: While powered down, a cycle with `frame_strobe` and `frame_speech` both high raises `pwr_en` from the next cycle, with `dom_rst_n` still low. A non-speech frame, or a speech level without a strobe, leaves the domain off.
- R3: `dom_rst_n` rises in the cycle after the 16th consecutive sampled cycle of `pwr_good` high. A low `pwr_good` cycle restarts that count.
- R4: While running, the domain powers down (`pwr_en` and `dom_rst_n` low from the next cycle) on the frame strobe that completes `hang_frames` consecutive non-speech frames. A `hang_frames` value of 0 acts as 1.
- R5: A speech frame during the hangover interval clears the non-speech count and keeps `dom_rst_n` high without any reset pulse.
- R6: Every cycle with `smp_valid` high stores `smp_data` at the next store position, whatever the power state.
- R7: At wake-up, the unread samples become the `preroll_len` samples stored before the waking cycle, oldest first, plus the sample stored in the waking cycle itself.
- R8: A read request made while unread samples exist produces `rd_valid` in the next cycle, with the oldest unread sample on `rd_data`.
- R9: A read request made while nothing is unread produces a one-cycle `rd_underflow` in the next cycle and no `rd_valid`. This covers requests made while powered down and in the waking cycle. A sample stored in the same cycle is not returned to that request.
- R10: A sample stored while 1024 samples are unread, with no read in that cycle, drops the oldest unread sample and sets `overflow`. A read and a write in the same cycle at a full store do not overflow. `overflow` stays set until the next wake-up clears it.
- R11: At power-down all unread samples are discarded, so later reads underflow until the next wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Audio sample strobe |
| smp_data | input | 16 | Audio sample |
| frame_strobe | input | 1 | Detector verdict strobe, one per frame |
| frame_speech | input | 1 | Verdict: 1 = speech |
| hang_frames | input | 8 | Non-speech frames before power-down (0 acts as 1) |
| preroll_len | input | 10 | Samples made readable from before wake-up |
| pwr_good | input | 1 | Supply-settled indication from the gated domain |
| pwr_en | output | 1 | Power-gate enable for the recognizer domain |
| dom_rst_n | output | 1 | Active-low reset of the recognizer domain |
| rd_req | input | 1 | Recognizer sample request |
| rd_valid | output | 1 | Requested sample is on `rd_data` |
| rd_data | output | 16 | Returned sample |
| rd_underflow | output | 1 | Request found no unread sample |
| overflow | output | 1 | Sticky: an unread sample was lost |

## Verification
The collisions of interest are a read request and a sample write in the same cycle. At an empty store this must underflow and not hand back the fresh sample. At a full store it must neither drop data nor flag overflow. The stimulus provokes the empty case by draining the store with a request every cycle while samples arrive every second cycle. It provokes the full case by letting 1100 samples pile up unread and then requesting while writing. A behavioural queue model in the bench follows every cycle and judges each outcome. The same model also covers a wake-up verdict that coincides with a read request and a sample, and a power-down frame that coincides with a read.

// File: rtl/wake_pkg.sv
// Shared types for the wake-up supervisor.
package wake_pkg;
    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_WAKING = 2'd1,
        PS_AWAKE  = 2'd2
    } pstate_t;
endpackage

// File: rtl/wake_pwr_seq.sv
// Power sequencer: turns frame verdicts into power-gate and reset control.
// Assumes frame_strobe is a single-cycle pulse per frame and that pwr_good
// is already synchronous to clk.
module wake_pwr_seq
    import wake_pkg::*;
#(
    parameter int SETTLE = 16,
    parameter int HW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_strobe,
    input  logic          frame_speech,
    input  logic [HW-1:0] hang_frames,
    input  logic          pwr_good,
    output pstate_t       state,
    output logic          wake_evt,
    output logic          sleep_evt
);
    localparam int SCW = $clog2(SETTLE + 1);

    logic [SCW-1:0] settle_q;
    logic [HW-1:0]  hang_q;
    logic [HW:0]    hang_lim;
    logic [HW:0]    hang_nxt;
    logic           settle_done;

    // Event decode: wake on a speech frame, sleep when the hangover runs out.
    always_comb begin
        hang_lim    = (hang_frames == '0) ? (HW+1)'(1) : {1'b0, hang_frames};
        hang_nxt    = {1'b0, hang_q} + (HW+1)'(1);
        settle_done = pwr_good && (settle_q == SCW'(SETTLE - 1));
        wake_evt    = (state == PS_OFF) && frame_strobe && frame_speech;
        sleep_evt   = (state == PS_AWAKE) && frame_strobe && !frame_speech
                      && (hang_nxt >= hang_lim);
    end

    // State register for the downstream domain.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  state <= PS_OFF;
        else if (wake_evt)                           state <= PS_WAKING;
        else if (state == PS_WAKING && settle_done)  state <= PS_AWAKE;
        else if (sleep_evt)                          state <= PS_OFF;
    end

    // Counts consecutive power-good cycles while waking.
    always_ff @(posedge clk) begin
        if (!rst_n || state != PS_WAKING || !pwr_good) settle_q <= '0;
        else                                           settle_q <= settle_q + SCW'(1);
    end

    // Counts consecutive non-speech frames while running.
    always_ff @(posedge clk) begin
        if (!rst_n || state != PS_AWAKE) hang_q <= '0;
        else if (frame_strobe)           hang_q <= frame_speech ? '0 : hang_nxt[HW-1:0];
    end

    // R2
    wake_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_OFF && frame_strobe && frame_speech) |=> (state == PS_WAKING));
    // R3
    release_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_AWAKE && $past(state) == PS_WAKING) |-> $past(pwr_good));
    // R5
    stay_on_speech_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_AWAKE && frame_strobe && frame_speech) |=> (state == PS_AWAKE));
    // R4
    sleep_only_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_AWAKE && !frame_strobe) |=> (state != PS_OFF));
endmodule

// File: rtl/wake_ring_buf.sv
// Circular sample store with pre-roll positioning and one-cycle pull reads.
// Assumes DEPTH is a power of two. Positions behind the write pointer that
// were never written hold undefined data. Unread accounting runs only while
// 'active' is high.
module wake_ring_buf #(
    parameter int DEPTH = 1024,
    parameter int SW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          wake,
    input  logic          sleep,
    input  logic [AW-1:0] preroll,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp_data,
    input  logic          rd_req,
    output logic          rd_valid,
    output logic [SW-1:0] rd_data,
    output logic          rd_underflow,
    output logic          overflow
);
    logic [SW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   occ;
    logic          full, do_rd, drop;

    // Read and overwrite decisions for this cycle.
    always_comb begin
        full  = (occ == (AW+1)'(DEPTH));
        do_rd = active && rd_req && (occ != '0);
        drop  = active && smp_valid && full && !do_rd;
    end

    // Write pointer: advances on every sample, in every state.
    always_ff @(posedge clk) begin
        if (!rst_n)         wp <= '0;
        else if (smp_valid) wp <= wp + AW'(1);
    end

    // Sample storage, no reset.
    always_ff @(posedge clk) begin
        if (smp_valid) mem[wp] <= smp_data;
    end

    // Read pointer and unread count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp  <= '0;
            occ <= '0;
        end else if (wake) begin
            rp  <= wp - preroll;
            occ <= {1'b0, preroll} + (AW+1)'(smp_valid);
        end else if (sleep) begin
            occ <= '0;
        end else if (drop) begin
            rp  <= rp + AW'(1);
        end else if (active) begin
            rp  <= rp + AW'(do_rd);
            occ <= occ + (AW+1)'(smp_valid) - (AW+1)'(do_rd);
        end
    end

    // Read response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid     <= 1'b0;
            rd_underflow <= 1'b0;
            rd_data      <= '0;
        end else begin
            rd_valid     <= do_rd;
            rd_underflow <= rd_req && !do_rd;
            if (do_rd) rd_data <= mem[rp];
        end
    end

    // Sticky overflow flag, cleared on wake-up.
    always_ff @(posedge clk) begin
        if (!rst_n || wake) overflow <= 1'b0;
        else if (drop)      overflow <= 1'b1;
    end

    // R10
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= (AW+1)'(DEPTH));
    // R9
    underflow_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && occ == '0) |=> (rd_underflow && !rd_valid));
    // R8
    read_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rd_req && occ != '0) |=> rd_valid);
    // R10
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(smp_valid && full));
    // R11
    sleep_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (occ == '0));
endmodule

// File: rtl/wake_supervisor.sv
// Top: the power sequencer plus the pre-roll sample store.
// Assumes every input is synchronous to clk.
module wake_supervisor
    import wake_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int SW     = 16,
    parameter int HW     = 8,
    parameter int SETTLE = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp_data,
    input  logic          frame_strobe,
    input  logic          frame_speech,
    input  logic [HW-1:0] hang_frames,
    input  logic [AW-1:0] preroll_len,
    input  logic          pwr_good,
    output logic          pwr_en,
    output logic          dom_rst_n,
    input  logic          rd_req,
    output logic          rd_valid,
    output logic [SW-1:0] rd_data,
    output logic          rd_underflow,
    output logic          overflow
);
    pstate_t state;
    logic    wake_evt, sleep_evt;

    wake_pwr_seq #(.SETTLE(SETTLE), .HW(HW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .frame_strobe(frame_strobe), .frame_speech(frame_speech),
        .hang_frames(hang_frames), .pwr_good(pwr_good),
        .state(state), .wake_evt(wake_evt), .sleep_evt(sleep_evt)
    );

    wake_ring_buf #(.DEPTH(DEPTH), .SW(SW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .active(state != PS_OFF), .wake(wake_evt), .sleep(sleep_evt),
        .preroll(preroll_len),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_underflow(rd_underflow), .overflow(overflow)
    );

    // Domain controls decoded from the sequencer state.
    always_comb begin
        pwr_en    = (state != PS_OFF);
        dom_rst_n = (state == PS_AWAKE);
    end

    // R3
    rst_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_rst_n) |-> $past(pwr_en && pwr_good));
endmodule

// File: tb/test_wake_supervisor.sv
`timescale 1ns/1ps
module test_wake_supervisor;
    localparam int DEPTH = 1024;
    localparam int SW = 16;
    localparam int MAXC = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 0, frame_strobe = 0, frame_speech = 0, rd_req = 0, pwr_good = 0;
    logic [SW-1:0] smp_data = '0;
    logic [7:0] hang_frames = 8'd3;
    logic [9:0] preroll_len = 10'd8;
    logic pwr_en, dom_rst_n, rd_valid, rd_underflow, overflow;
    logic [SW-1:0] rd_data;

    always #2 clk = ~clk;   // 250 MHz

    wake_supervisor i_wake_supervisor (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .frame_strobe(frame_strobe), .frame_speech(frame_speech),
        .hang_frames(hang_frames), .preroll_len(preroll_len), .pwr_good(pwr_good),
        .pwr_en(pwr_en), .dom_rst_n(dom_rst_n), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_underflow(rd_underflow), .overflow(overflow)
    );

    int errs = 0, checks = 0, cyc = 0;
    bit started = 0;

    // ---------------- reference model ----------------
    logic [SW-1:0] hist[$];
    logic [SW-1:0] pend[$];
    int  mst = 0, msettle = 0, mhang = 0, lim = 1;
    bit  e_rv = 0, e_uf = 0, e_ovf = 0, m_wake, m_sleep;
    logic [SW-1:0] e_dat = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; msettle = 0; mhang = 0; e_rv = 0; e_uf = 0; e_ovf = 0;
            pend.delete(); started = 1;
        end else begin
            lim = (hang_frames == 0) ? 1 : int'(hang_frames);
            m_wake  = (mst == 0) && frame_strobe && frame_speech;
            m_sleep = (mst == 2) && frame_strobe && !frame_speech && (mhang + 1 >= lim);
            e_rv = 0; e_uf = 0;
            if (mst != 0) begin
                if (rd_req) begin
                    if (pend.size() > 0) begin e_rv = 1; e_dat = pend.pop_front(); end
                    else e_uf = 1;
                end
                if (smp_valid) begin
                    if (pend.size() == DEPTH) begin void'(pend.pop_front()); e_ovf = 1; end
                    pend.push_back(smp_data);
                end
            end else if (rd_req) e_uf = 1;
            if (m_sleep) pend.delete();
            if (m_wake) begin
                pend.delete();
                for (int k = hist.size() - int'(preroll_len); k < hist.size(); k++)
                    pend.push_back(hist[k]);
                if (smp_valid) pend.push_back(smp_data);
                e_ovf = 0;
            end
            if (smp_valid) begin
                hist.push_back(smp_data);
                if (hist.size() > 2048) void'(hist.pop_front());
            end
            // state update
            if (m_wake) begin mst = 1; msettle = 0; end
            else if (mst == 1) begin
                if (pwr_good) begin
                    if (msettle == 15) begin mst = 2; mhang = 0; end
                    else msettle++;
                end else msettle = 0;
            end else if (mst == 2 && frame_strobe) begin
                if (frame_speech) mhang = 0;
                else if (m_sleep) mst = 0;
                else mhang++;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    always @(negedge clk) begin
        if (started && rst_n) begin
            chk("R2/R4 pwr_en", 32'(pwr_en), 32'(mst != 0));
            chk("R3/R5 dom_rst_n", 32'(dom_rst_n), 32'(mst == 2));
            chk("R8/R11 rd_valid", 32'(rd_valid), 32'(e_rv));
            if (e_rv) chk("R6/R7/R8 rd_data", 32'(rd_data), 32'(e_dat));
            chk("R9 rd_underflow", 32'(rd_underflow), 32'(e_uf));
            chk("R10 overflow", 32'(overflow), 32'(e_ovf));
        end
    end

    // Gated-domain supply model: pwr_good follows pwr_en after 6 cycles, one glitch.
    int  pg_cnt = 0;
    bit  glitch_en = 0;
    always @(negedge clk) begin
        if (!pwr_en) begin pg_cnt = 0; pwr_good = 0; end
        else begin
            pg_cnt++;
            pwr_good = (pg_cnt >= 6) && !(glitch_en && pg_cnt == 10);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > MAXC) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, MAXC);
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc1(bit v, bit fs, bit sp, bit rq);
        smp_valid = v;
        if (v) smp_data = smp_data + 16'd1;
        frame_strobe = fs; frame_speech = sp; rd_req = rq;
        @(negedge clk);
    endtask

    task automatic run(int n, int vev, int fev, bit sp, int rev);
        for (int i = 0; i < n; i++)
            cyc1(vev != 0 && i % vev == 0, fev != 0 && i % fev == fev - 1, sp,
                 rev != 0 && i % rev == 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pwr_en", 32'(pwr_en), 0);
        chk("R1 dom_rst_n", 32'(dom_rst_n), 0);
        chk("R1 rd_valid", 32'(rd_valid), 0);
        chk("R1 rd_underflow", 32'(rd_underflow), 0);
        chk("R1 overflow", 32'(overflow), 0);
        rst_n = 1;
        // R6/R11/R9: samples stored while off, non-speech frames, reads underflow
        run(1100, 1, 8, 0, 50);
        run(6, 1, 0, 1, 0);              // R2: speech level without strobe
        // R2/R7/R9: wake with a read and a sample in the same cycle
        glitch_en = 1;
        cyc1(1, 1, 1, 1);
        run(40, 2, 0, 0, 0);             // R3: settle with a pwr_good drop
        glitch_en = 0;
        run(30, 2, 0, 0, 1);             // R8/R9: drain, read+write at empty
        // R4/R5: hangover, cancelled by speech, then expires
        run(16, 1, 8, 0, 3);
        cyc1(1, 1, 1, 0);
        run(24, 1, 8, 0, 3);
        run(10, 1, 0, 0, 1);             // R11: reads after power-down
        // R10: overflow, full read+write, sticky, hang_frames=0
        preroll_len = 10'd0; hang_frames = 8'd0;
        cyc1(1, 1, 1, 0);
        run(1100, 1, 200, 1, 0);
        run(5, 1, 0, 0, 1);
        run(5, 0, 0, 0, 1);
        cyc1(0, 1, 0, 0);
        run(5, 1, 0, 0, 0);
        // R10: next wake clears the flag
        preroll_len = 10'd4; hang_frames = 8'd2;
        cyc1(1, 1, 1, 0);
        run(40, 1, 0, 0, 2);
        summary();
        $finish;
    end
endmodule